// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 12-bit successive-approximation converter. A start request moves it out of idle. It clears its approximation register and pulls an active-low busy flag low. It then walks a single test bit from the most significant position down to the least significant one, one bit per rising converter-clock edge. The trial word goes to an external DAC. A one-bit comparator answer tells the sequencer whether the analog input sits at or above that trial level.

A conversion always takes the same fixed 13-edge schedule. There is one settling edge after the start, followed by twelve decision edges. Once a conversion has begun it runs to completion, and any further start requests are dropped. On the last decision edge the finished code is copied into an output latch and busy goes high again. Until that edge the latch keeps the code from the previous conversion.

Top module: `sar_sequencer`

## Requirements
- R1: With busyN high, a high startReq at a rising edge begins a conversion. From that edge on, busyN is low, and trialWord reads 0 until the next edge.
- R2: Bits are tested strictly from bit 11 (MSB) down to bit 0 (LSB).
- R3: The first rising edge after the start edge puts 0x800 on trialWord. The MSB decision is made at the second rising edge after the start edge.
- R4: Each of the next 11 rising edges decides exactly one further bit.
- R5: busyN stays low for exactly 13 clock cycles. It goes high at the 13th rising edge after the start edge.
- R6: A startReq that arrives while busyN is low has no effect. The running conversion neither restarts nor stops.
- R7: resultWord keeps the previous code until the edge at which busyN goes high, and takes the new code at that edge. Outside a conversion, trialWord shows the last decided code.
- R8: The result is natural binary (0 to 4095, bit 11 the MSB). With a comparator that reports input code >= trialWord, the result equals the input code.
- R9: During a trial, trialWord is the bits already decided, with the bit under test set to 1 and all lower bits 0. The bit is kept when cmpHigh is 1 at the deciding edge and cleared when cmpHigh is 0.
- R10: While rstN is low (asynchronous), busyN is 1, and trialWord and resultWord are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; all decisions on rising edges |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Conversion request, sampled on rising edges |
| cmpHigh | input | 1 | Comparator: 1 when the input is at or above trialWord |
| busyN | output | 1 | Low while a conversion runs |
| trialWord | output | 12 | Trial code driven to the external DAC |
| resultWord | output | 12 | Latched result of the last finished conversion |

## Verification
The assertions assume that cmpHigh depends only on trialWord and on an analog level that stays constant for the whole conversion. The bench respects this by deriving cmpHigh combinationally from a code it changes only while busyN is high. The assertions also assume that startReq changes only between clock edges. The bench therefore drives every input on falling edges. Start requests are deliberately raised during conversions so that the ignored-start property is exercised, not just left vacuous.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_TRIAL  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic clearSar;
    logic testActive;
    logic decide;
    logic loadResult;
  } seqStrobe_t;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 12,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  output seqStrobe_t       strobe,
  output logic [IDX_W-1:0] bitIdx,
  output logic             busyN
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);

  seqState_t stateQ;
  logic [IDX_W-1:0] idxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: if (startReq) stateQ <= ST_SETTLE;
        ST_SETTLE: begin
          stateQ <= ST_TRIAL;
          idxQ   <= TOP_IDX;
        end
        ST_TRIAL: begin
          if (idxQ == '0) stateQ <= ST_IDLE;
          else            idxQ   <= idxQ - 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clearSar   = (stateQ == ST_IDLE) && startReq;
    strobe.testActive = (stateQ == ST_TRIAL);
    strobe.decide     = (stateQ == ST_TRIAL);
    strobe.loadResult = (stateQ == ST_TRIAL) && (idxQ == '0);
  end

  assign bitIdx = idxQ;
  assign busyN  = (stateQ == ST_IDLE);

  AST_START_TAKES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && busyN) |=> !busyN); // R1
  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SETTLE) |=> (stateQ == ST_TRIAL && idxQ == TOP_IDX)); // R3
  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_TRIAL && idxQ != '0) |=> (stateQ == ST_TRIAL && idxQ == $past(idxQ) - 1'b1)); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (!busyN && startReq) |=> (stateQ != ST_SETTLE)); // R6
  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_TRIAL && idxQ == '0) |=> busyN); // R5

endmodule

// File: rtl/sar_seq_datapath.sv
module sar_seq_datapath
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 12,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] trialWord,
  output logic [WIDTH-1:0] resultWord
);

  logic [WIDTH-1:0] sarQ;
  logic [WIDTH-1:0] resultQ;
  logic [WIDTH-1:0] testMask;
  logic [WIDTH-1:0] nextSar;

  assign testMask = {{(WIDTH-1){1'b0}}, 1'b1} << bitIdx;

  always_comb begin
    nextSar = sarQ;
    if (strobe.decide && cmpHigh) nextSar = sarQ | testMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarQ    <= '0;
      resultQ <= '0;
    end else begin
      if (strobe.clearSar)   sarQ    <= '0;
      else if (strobe.decide) sarQ   <= nextSar;
      if (strobe.loadResult) resultQ <= nextSar;
    end
  end

  assign trialWord  = strobe.testActive ? (sarQ | testMask) : sarQ;
  assign resultWord = resultQ;

  AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.testActive |-> ((sarQ & (testMask | (testMask - 1'b1))) == '0)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadResult |=> $stable(resultWord)); // R7

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             cmpHigh,
  output logic             busyN,
  output logic [WIDTH-1:0] trialWord,
  output logic [WIDTH-1:0] resultWord
);

  localparam int IDX_W = $clog2(WIDTH);

  seqStrobe_t       strobe;
  logic [IDX_W-1:0] bitIdx;

  sar_seq_ctrl #(.WIDTH(WIDTH)) ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .strobe(strobe), .bitIdx(bitIdx), .busyN(busyN)
  );

  sar_seq_datapath #(.WIDTH(WIDTH)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIdx(bitIdx),
    .cmpHigh(cmpHigh), .trialWord(trialWord), .resultWord(resultWord)
  );

endmodule

// File: tb/sar_sequencer_test.sv
module sar_sequencer_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic cmpHigh;
  logic busyN;
  logic [11:0] trialWord;
  logic [11:0] resultWord;

  int analogCode = 0;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  int refPhase = 0;
  int refSar = 0;
  int refResult = 0;

  always #4 clk = ~clk;

  assign cmpHigh = (analogCode >= int'(trialWord));

  sar_sequencer uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpHigh(cmpHigh),
    .busyN(busyN), .trialWord(trialWord), .resultWord(resultWord)
  );

  function automatic int refTrial();
    if (refPhase >= 2) return refSar | (1 << (13 - refPhase));
    return refSar;
  endfunction

  always @(posedge clk) begin
    if (rstN) begin
      if (refPhase == 0) begin
        if (startReq) begin refPhase = 1; refSar = 0; end
      end else if (refPhase == 1) begin
        refPhase = 2;
      end else begin
        if (analogCode >= refTrial()) refSar = refTrial();
        if (refPhase == 13) begin refResult = refSar; refPhase = 0; end
        else refPhase = refPhase + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(busyN == (refPhase == 0), "R5 busy", busyN, refPhase == 0);
      check(int'(trialWord) == refTrial(), "R2 R4 R9 trial", trialWord, refTrial());
      check(int'(resultWord) == refResult, "R7 R8 result", resultWord, refResult);
    end
  end

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      check(0, "watchdog", cycles, 100000);
      summary();
    end
  end

  task automatic runConv(input int code, input int restartAt);
    int prevResult;
    prevResult = int'(resultWord);
    @(negedge clk);
    analogCode = code;
    startReq = 1'b1;
    @(negedge clk);                       // after start edge
    startReq = 1'b0;
    check(busyN == 1'b0, "R1 busy low", busyN, 0);
    check(trialWord == 12'd0, "R1 cleared", trialWord, 0);
    @(negedge clk);                       // after first edge
    check(trialWord == 12'h800, "R3 msb trial", trialWord, 2048);
    for (int k = 2; k <= 13; k++) begin
      startReq = (k == restartAt);
      @(negedge clk);
      if (k == 12) begin
        check(busyN == 1'b0, "R5 still busy", busyN, 0);
        check(int'(resultWord) == prevResult, "R7 hold", resultWord, prevResult);
      end
    end
    startReq = 1'b0;
    check(busyN == 1'b1, "R5 busy end", busyN, 1);
    check(int'(resultWord) == code, "R8 code", resultWord, code);
    check(int'(trialWord) == code, "R7 trial shows code", trialWord, code);
    @(negedge clk);
    check(busyN == 1'b1, "R6 no restart", busyN, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busyN == 1'b1, "R10 busy", busyN, 1);
    check(trialWord == 12'd0, "R10 trial", trialWord, 0);
    check(resultWord == 12'd0, "R10 result", resultWord, 0);
    rstN = 1'b1;
    runConv(0, 0);
    runConv(4095, 0);
    runConv(2048, 0);
    runConv(2047, 0);
    runConv(1365, 5);     // R6: start mid-conversion
    runConv(2730, 13);    // R6: start on final edge
    runConv(1, 2);
    for (int i = 0; i < 40; i++) runConv((i * 1031 + 77) % 4096, (i % 3 == 0) ? 7 : 0);
    // idle start pulses back to back
    runConv(3000, 0);
    runConv(3001, 0);
    summary();
  end

endmodule